// File: doc/BRIEF.md
# Two-Channel DMA Controller with Bounded Forced Stop

This block moves single bytes between a fixed peripheral register and an incrementing RAM address over a single-master byte bus. There are two channels. Each one has a control register, a transfer count, a RAM address and a peripheral address, plus one hardware trigger input and one completion interrupt output. Software fills in the count and the addresses and then sets enable and start. After that, each rising edge on the channel's trigger moves one byte. The byte goes in one of two directions, chosen by a direction bit. Every move is a read cycle followed by a write cycle. The block requests the bus through a request/grant pair first.

The centre of the design is the control sequence of each channel. Software can stop a channel in three ways:
- A hold bit parks requests that are waiting.
- Clearing start ends the channel's activity within two clocks. The start bit reads back as 1 until the channel has really stopped, so software can poll it.
- Clearing enable afterwards returns the channel to idle.

When both channels are ready in the same cycle, channel 0 is served first. Control registers use this layout: bit 7 is enable, bit 2 is direction, bit 1 is hold and bit 0 is start.

Top module: `dma2_ctl`

## Requirements
- R1: After reset, both control registers read 0, `bus_req`, `bus_en` and both interrupts are 0.
- R2: Each completed move decrements the channel count (register index 1) and increments its RAM address (index 2) by one; the peripheral address (index 3) does not change. Register address = {channel, index}.
- R3: Direction bit 2 = 0 moves the peripheral byte at {0xFF, peripheral address} to RAM; 1 moves the RAM byte to that peripheral address. A read bus cycle (`bus_en`=1, `bus_we`=0) at the source is always followed in the next cycle by a write cycle at the destination, and then the bus goes idle.
- R4: `bus_req` stays high until `bus_gnt` is seen; the read cycle starts in the cycle after the grant and never overlaps `bus_req`.
- R5: When both channels are ready together, channel 0 moves its byte first.
- R6: A trigger rising edge while enable=1, start=1 and hold=0 latches one pending request; further edges before that request is taken merge into it. Edges while hold=1 are dropped and are not replayed later.
- R7: While hold (bit 1) is 1, the channel starts no new bus request and withdraws a request that has not yet been granted; clearing hold lets the parked request proceed.
- R8: When the count reaches 0, start clears by itself (control reads 0x80) and the channel interrupt is high for exactly one clock; later triggers move nothing.
- R9: Writing 0x80 to a running channel leaves start reading 1 on the next read. Start reads 0 within 2 clocks of the write, and after that no move occurs.
- R10: A move whose read cycle has already been granted when start is cleared completes its write and updates count and address before the channel stops.
- R11: Writing 0x00 after a stop clears enable and drops any parked request; re-enabling does not replay it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | {channel, register index} |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Registered read data for `cfg_addr`, one clock behind |
| dma_trig | input | 2 | Per-channel transfer trigger |
| dma_irq | output | 2 | Per-channel completion pulse |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_en | output | 1 | Bus cycle active |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid during a read cycle |

## Verification
The first timing rule is for a trigger edge. When the grant is free, the trigger edge is latched at the next clock, the request rises one clock later, the read follows the grant edge and the write follows the read. So each move is done within five clocks, and the bench waits ten or more before it inspects memory.

The second timing rule is for a forced stop. The write takes effect at clock E0, and start clears by E2 at the latest. `cfg_rdata` is registered and shows state one clock late. For that reason the bench samples start one read after the write, where it expects 1, and three reads after it, where it expects 0.

Register reads take two falling edges so that they return settled state. Interrupts are counted at every rising edge and compared only after the whole move sequence.

// File: rtl/dma2_pkg.sv
package dma2_pkg;
  localparam int NCH = 2;
  localparam int IDXW = 2;

  localparam logic [IDXW-1:0] RI_CTRL = 2'd0;
  localparam logic [IDXW-1:0] RI_CNT  = 2'd1;
  localparam logic [IDXW-1:0] RI_RAM  = 2'd2;
  localparam logic [IDXW-1:0] RI_PER  = 2'd3;

  localparam int CB_EN  = 7;
  localparam int CB_DIR = 2;
  localparam int CB_HLD = 1;
  localparam int CB_GO  = 0;

  typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_RD, SQ_WR} sq_state_t;
endpackage

// File: rtl/dma2_chan.sv
module dma2_chan
  import dma2_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int RAM_W = 16,
  parameter int PER_W = 8,
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDXW-1:0]  wr_idx,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             trig,
  input  logic             busy,
  input  logic             done,
  input  logic             take,
  output logic             ready,
  output logic             dir,
  output logic [RAM_W-1:0] ram_a,
  output logic [PER_W-1:0] per_a,
  output logic [7:0]       ctrl_rd,
  output logic [CNT_W-1:0] cnt_rd,
  output logic             irq,
  output logic             stopping
);
  logic en, go, hld, pend, trig_q;
  logic [CNT_W-1:0] cnt;
  logic trig_edge;

  assign trig_edge = trig & ~trig_q;
  assign ready     = pend & en & go & ~hld & ~stopping & (cnt != '0);
  assign ctrl_rd   = {en, 4'b0000, dir, hld, go};
  assign cnt_rd    = cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      en <= 1'b0; go <= 1'b0; hld <= 1'b0; dir <= 1'b0;
      pend <= 1'b0; trig_q <= 1'b0; stopping <= 1'b0; irq <= 1'b0;
      cnt <= '0; ram_a <= '0; per_a <= '0;
    end else begin
      trig_q <= trig;
      irq    <= 1'b0;
      if (trig_edge && en && go && !hld && !stopping) pend <= 1'b1;
      else if (take) pend <= 1'b0;
      if (done) begin
        cnt   <= cnt - 1'b1;
        ram_a <= ram_a + 1'b1;
        if (cnt == CNT_W'(1)) begin
          go <= 1'b0; stopping <= 1'b0; pend <= 1'b0; irq <= 1'b1;
        end
      end
      if (stopping && (!busy || done)) begin
        go <= 1'b0; stopping <= 1'b0; pend <= 1'b0;
      end
      if (wr_en) begin
        case (wr_idx)
          RI_CTRL: begin
            en  <= wr_data[CB_EN];
            hld <= wr_data[CB_HLD];
            dir <= wr_data[CB_DIR];
            if (!wr_data[CB_EN]) begin
              go <= 1'b0; stopping <= 1'b0; pend <= 1'b0;
            end else if (wr_data[CB_GO]) begin
              if (!go) go <= 1'b1;
            end else if (go && !stopping) begin
              stopping <= 1'b1;
            end
          end
          RI_CNT:  cnt   <= wr_data[CNT_W-1:0];
          RI_RAM:  ram_a <= wr_data[RAM_W-1:0];
          default: per_a <= wr_data[PER_W-1:0];
        endcase
      end
    end
  end
endmodule

// File: rtl/dma2_seq.sv
module dma2_seq
  import dma2_pkg::*;
#(
  parameter int CH    = 2,
  parameter int RAM_W = 16,
  parameter int PER_W = 8,
  parameter int DW    = 8,
  parameter logic [RAM_W-PER_W-1:0] PER_PAGE = '1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [CH-1:0]              ready,
  input  logic [CH-1:0]              dir,
  input  logic [CH-1:0][RAM_W-1:0]   ram_a,
  input  logic [CH-1:0][PER_W-1:0]   per_a,
  output logic [CH-1:0]              take,
  output logic [CH-1:0]              busy,
  output logic [CH-1:0]              done,
  output logic                       bus_req,
  input  logic                       bus_gnt,
  output logic                       bus_en,
  output logic                       bus_we,
  output logic [RAM_W-1:0]           bus_addr,
  output logic [DW-1:0]              bus_wdata,
  input  logic [DW-1:0]              bus_rdata
);
  localparam int IW = (CH > 1) ? $clog2(CH) : 1;

  sq_state_t st_q;
  logic [IW-1:0] own_q, pick;
  logic any;
  logic [RAM_W-1:0] per_full, src, dst;

  always_comb begin
    any  = 1'b0;
    pick = '0;
    for (int i = CH - 1; i >= 0; i--) begin
      if (ready[i]) begin
        any  = 1'b1;
        pick = IW'(i);
      end
    end
  end

  assign per_full = {PER_PAGE, per_a[own_q]};
  assign src = dir[own_q] ? ram_a[own_q] : per_full;
  assign dst = dir[own_q] ? per_full : ram_a[own_q];

  for (genvar g = 0; g < CH; g++) begin : g_flags
    assign take[g] = (st_q == SQ_REQ) && (own_q == IW'(g)) && ready[g] && bus_gnt;
    assign busy[g] = ((st_q == SQ_RD) || (st_q == SQ_WR)) && (own_q == IW'(g));
    assign done[g] = (st_q == SQ_WR) && (own_q == IW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= SQ_IDLE; own_q <= '0;
      bus_req <= 1'b0; bus_en <= 1'b0; bus_we <= 1'b0;
      bus_addr <= '0; bus_wdata <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: if (any) begin
          st_q <= SQ_REQ; own_q <= pick; bus_req <= 1'b1;
        end
        SQ_REQ: begin
          if (!ready[own_q]) begin
            st_q <= SQ_IDLE; bus_req <= 1'b0;
          end else if (bus_gnt) begin
            st_q <= SQ_RD; bus_req <= 1'b0;
            bus_en <= 1'b1; bus_we <= 1'b0; bus_addr <= src;
          end
        end
        SQ_RD: begin
          st_q <= SQ_WR; bus_we <= 1'b1;
          bus_addr <= dst; bus_wdata <= bus_rdata;
        end
        default: begin
          st_q <= SQ_IDLE; bus_en <= 1'b0; bus_we <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/dma2_ctl.sv
module dma2_ctl
  import dma2_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int RAM_W = 16,
  parameter int PER_W = 8,
  parameter int DW    = 8,
  parameter int CFG_W = 16,
  localparam int CSW  = $clog2(NCH),
  localparam int AW   = CSW + IDXW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic [NCH-1:0]   dma_trig,
  output logic [NCH-1:0]   dma_irq,
  output logic             bus_req,
  input  logic             bus_gnt,
  output logic             bus_en,
  output logic             bus_we,
  output logic [RAM_W-1:0] bus_addr,
  output logic [DW-1:0]    bus_wdata,
  input  logic [DW-1:0]    bus_rdata
);
  logic [NCH-1:0] ready, dir, take, busy, done, stop_pend;
  logic [NCH-1:0][RAM_W-1:0] ram_a;
  logic [NCH-1:0][PER_W-1:0] per_a;
  logic [NCH-1:0][7:0] ctrl_rd;
  logic [NCH-1:0][CNT_W-1:0] cnt_rd;
  logic [CSW-1:0] csel;
  logic [IDXW-1:0] ridx;

  assign csel = cfg_addr[AW-1:IDXW];
  assign ridx = cfg_addr[IDXW-1:0];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dma2_chan #(.CNT_W(CNT_W), .RAM_W(RAM_W), .PER_W(PER_W), .CFG_W(CFG_W)) u_chan (
      .clk(clk), .rst(rst),
      .wr_en(cfg_we && (csel == CSW'(g))), .wr_idx(ridx), .wr_data(cfg_wdata),
      .trig(dma_trig[g]), .busy(busy[g]), .done(done[g]), .take(take[g]),
      .ready(ready[g]), .dir(dir[g]), .ram_a(ram_a[g]), .per_a(per_a[g]),
      .ctrl_rd(ctrl_rd[g]), .cnt_rd(cnt_rd[g]), .irq(dma_irq[g]),
      .stopping(stop_pend[g])
    );
  end

  dma2_seq #(.CH(NCH), .RAM_W(RAM_W), .PER_W(PER_W), .DW(DW)) u_seq (
    .clk(clk), .rst(rst), .ready(ready), .dir(dir), .ram_a(ram_a), .per_a(per_a),
    .take(take), .busy(busy), .done(done),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else begin
      case (ridx)
        RI_CTRL: cfg_rdata <= CFG_W'(ctrl_rd[csel]);
        RI_CNT:  cfg_rdata <= CFG_W'(cnt_rd[csel]);
        RI_RAM:  cfg_rdata <= CFG_W'(ram_a[csel]);
        default: cfg_rdata <= CFG_W'(per_a[csel]);
      endcase
    end
  end
endmodule

// File: rtl/dma2_chk.sv
module dma2_chk #(parameter int CH = 2) (
  input logic          clk,
  input logic          rst,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          bus_en,
  input logic          bus_we,
  input logic [CH-1:0] dma_irq,
  input logic [CH-1:0] stop_pend
);
  // R4
  grant_before_read_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_en) |-> $past(bus_req && bus_gnt));
  // R4
  req_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && bus_en));
  // R3
  read_then_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !bus_we) |=> (bus_en && bus_we));
  // R3
  write_ends_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_we) |=> !bus_en);

  for (genvar g = 0; g < CH; g++) begin : g_chk
    // R8
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      dma_irq[g] |=> !dma_irq[g]);
    // R9
    stop_bound_chk: assert property (@(posedge clk) disable iff (rst)
      (stop_pend[g] && $past(stop_pend[g])) |=> !stop_pend[g]);
  end
endmodule

bind dma2_ctl dma2_chk #(.CH(dma2_pkg::NCH)) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .bus_en(bus_en), .bus_we(bus_we), .dma_irq(dma_irq), .stop_pend(stop_pend)
);

// File: tb/dma2_ctl_tb_top.sv
module dma2_ctl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [1:0] dma_trig = '0;
  logic [1:0] dma_irq;
  logic bus_req, bus_gnt, bus_en, bus_we;
  logic [15:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic allow_gnt = 1'b0;

  logic [7:0] ram_m [0:255];
  logic [7:0] per_m [0:255];
  int wr_count = 0, log_n = 0, irq0_cnt = 0, irq1_cnt = 0;
  logic [15:0] wr_log [0:7];
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  assign bus_gnt   = bus_req & allow_gnt;
  assign bus_rdata = (bus_addr[15:8] == 8'hFF) ? per_m[bus_addr[7:0]] : ram_m[bus_addr[7:0]];

  dma2_ctl dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .dma_trig(dma_trig), .dma_irq(dma_irq),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always @(posedge clk) begin
    if (dma_irq[0]) irq0_cnt++;
    if (dma_irq[1]) irq1_cnt++;
    if (bus_en && bus_we) begin
      if (bus_addr[15:8] == 8'hFF) per_m[bus_addr[7:0]] = bus_wdata;
      else ram_m[bus_addr[7:0]] = bus_wdata;
      wr_count++;
      if (log_n < 8) wr_log[log_n] = bus_addr;
      log_n++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input int ch, input int idx, input logic [15:0] v);
    @(negedge clk);
    cfg_addr = {ch[0], idx[1:0]}; cfg_wdata = v; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input int ch, input int idx, output logic [15:0] v);
    @(negedge clk);
    cfg_addr = {ch[0], idx[1:0]};
    @(negedge clk);
    @(negedge clk);
    v = cfg_rdata;
  endtask

  task automatic pulse(input logic [1:0] m);
    @(negedge clk); dma_trig = m;
    @(negedge clk); dma_trig = 2'b00;
  endtask

  // Write 0x80 and poll start with registered reads; optionally release grant on the same edge.
  task automatic stop_poll(input int ch, input bit gnt_too, input string tag);
    @(negedge clk);
    cfg_addr = {ch[0], 2'd0}; cfg_wdata = 16'h0080; cfg_we = 1'b1;
    if (gnt_too) allow_gnt = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
    @(negedge clk); chk({tag, " start still reads 1"}, 32'(cfg_rdata[0]), 32'd1);
    @(negedge clk);
    @(negedge clk); chk({tag, " start 0 within 2 clocks"}, 32'(cfg_rdata[0]), 32'd0);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(0, 0, v); chk("R1 ctrl0", 32'(v), 0);
    rd(1, 0, v); chk("R1 ctrl1", 32'(v), 0);
    chk("R1 bus_req", 32'(bus_req), 0);
    chk("R1 bus_en", 32'(bus_en), 0);
    chk("R1 irq", 32'(dma_irq), 0);
  endtask

  task automatic t_p2r;
    logic [15:0] v; int base;
    per_m[8'h10] = 8'hA5; allow_gnt = 1'b1;
    wr(0, 1, 16'd3); wr(0, 2, 16'h0020); wr(0, 3, 16'h0010); wr(0, 0, 16'h0081);
    pulse(2'b01); idle(10);
    chk("R3 periph to ram", 32'(ram_m[8'h20]), 32'hA5);
    rd(0, 1, v); chk("R2 count dec", 32'(v), 2);
    rd(0, 2, v); chk("R2 ram inc", 32'(v), 32'h21);
    rd(0, 3, v); chk("R2 periph fixed", 32'(v), 32'h10);
    per_m[8'h10] = 8'h5A;
    pulse(2'b01); idle(10);
    chk("R2 second byte", 32'(ram_m[8'h21]), 32'h5A);
    chk("R8 no irq early", 32'(irq0_cnt), 0);
    pulse(2'b01); idle(10);
    chk("R8 irq once", 32'(irq0_cnt), 1);
    rd(0, 0, v); chk("R8 start cleared", 32'(v), 32'h80);
    base = wr_count;
    pulse(2'b01); idle(10);
    chk("R8 no move after end", 32'(wr_count), 32'(base));
  endtask

  task automatic t_handshake;
    int base;
    per_m[8'h31] = 8'h77; allow_gnt = 1'b0;
    wr(1, 1, 16'd5); wr(1, 2, 16'h0041); wr(1, 3, 16'h0031); wr(1, 0, 16'h0081);
    base = wr_count;
    pulse(2'b10); idle(6);
    chk("R4 req held", 32'(bus_req), 1);
    chk("R4 no cycle before grant", 32'(bus_en), 0);
    chk("R4 no write before grant", 32'(wr_count), 32'(base));
    allow_gnt = 1'b1; idle(8);
    chk("R4 move after grant", 32'(ram_m[8'h41]), 32'h77);
    chk("R4 req released", 32'(bus_req), 0);
  endtask

  task automatic t_r2p;
    ram_m[8'h42] = 8'h3C;
    wr(1, 2, 16'h0042); wr(1, 3, 16'h0030); wr(1, 0, 16'h0085);
    pulse(2'b10); idle(10);
    chk("R3 ram to periph", 32'(per_m[8'h30]), 32'h3C);
  endtask

  task automatic t_priority;
    per_m[8'h50] = 8'h11; per_m[8'h51] = 8'h22;
    wr(0, 1, 16'd4); wr(0, 2, 16'h0060); wr(0, 3, 16'h0050); wr(0, 0, 16'h0081);
    wr(1, 1, 16'd4); wr(1, 2, 16'h0070); wr(1, 3, 16'h0051); wr(1, 0, 16'h0081);
    allow_gnt = 1'b0; log_n = 0;
    pulse(2'b11); idle(5);
    allow_gnt = 1'b1; idle(15);
    chk("R5 ch0 first", 32'(wr_log[0]), 32'h0060);
    chk("R5 ch1 second", 32'(wr_log[1]), 32'h0070);
    chk("R5 ch1 data", 32'(ram_m[8'h70]), 32'h22);
  endtask

  task automatic t_pending;
    logic [15:0] v; int base;
    allow_gnt = 1'b1; base = wr_count;
    pulse(2'b01); pulse(2'b01); pulse(2'b01); idle(12);
    chk("R6 merged pending", 32'(wr_count), 32'(base + 2));
    rd(0, 1, v); chk("R6 count", 32'(v), 1);
    base = wr_count;
    wr(0, 0, 16'h0083); pulse(2'b01); idle(8);
    wr(0, 0, 16'h0081); idle(10);
    chk("R6 edge under hold dropped", 32'(wr_count), 32'(base));
  endtask

  task automatic t_hold;
    int base;
    allow_gnt = 1'b0; base = wr_count;
    pulse(2'b10); idle(4);
    chk("R7 request up", 32'(bus_req), 1);
    wr(1, 0, 16'h0083); idle(2);
    chk("R7 request withdrawn", 32'(bus_req), 0);
    allow_gnt = 1'b1; idle(10);
    chk("R7 held no move", 32'(wr_count), 32'(base));
    wr(1, 0, 16'h0081); idle(10);
    chk("R7 resumes", 32'(wr_count), 32'(base + 1));
  endtask

  task automatic t_stop_idle;
    logic [15:0] v; int base;
    base = wr_count;
    stop_poll(1, 1'b0, "R9 idle stop");
    pulse(2'b10); idle(10);
    chk("R9 no move after stop", 32'(wr_count), 32'(base));
    rd(1, 0, v); chk("R9 enable kept", 32'(v), 32'h80);
  endtask

  task automatic t_stop_inflight;
    logic [15:0] v; int base;
    wr(0, 1, 16'd5);
    allow_gnt = 1'b0;
    pulse(2'b01); idle(4);
    base = wr_count;
    stop_poll(0, 1'b1, "R10 busy stop");
    chk("R10 write completed", 32'(wr_count), 32'(base + 1));
    rd(0, 1, v); chk("R10 count updated", 32'(v), 4);
    pulse(2'b01); idle(10);
    chk("R10 nothing after", 32'(wr_count), 32'(base + 1));
  endtask

  task automatic t_disable;
    logic [15:0] v; int base;
    wr(1, 0, 16'h0081);
    allow_gnt = 1'b0; base = wr_count;
    pulse(2'b10); idle(4);
    wr(1, 0, 16'h0080); idle(4);
    wr(1, 0, 16'h0000); idle(2);
    rd(1, 0, v); chk("R11 ctrl idle", 32'(v), 0);
    allow_gnt = 1'b1; idle(10);
    chk("R11 no move", 32'(wr_count), 32'(base));
    chk("R11 no request", 32'(bus_req), 0);
    wr(1, 0, 16'h0081); idle(10);
    chk("R11 pending not replayed", 32'(wr_count), 32'(base));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin ram_m[i] = 8'h00; per_m[i] = 8'h00; end
    for (int i = 0; i < 8; i++) wr_log[i] = 16'h0000;
    idle(3);
    rst = 1'b0;
    idle(2);
    t_reset();
    t_p2r();
    t_handshake();
    t_r2p();
    t_priority();
    t_pending();
    t_hold();
    t_stop_idle();
    t_stop_inflight();
    t_disable();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule